// File: doc/BRIEF.md
# Two-Level Storage Host Interrupt Register Block

This block collects interrupt events from the ports of a multi-port storage host controller and presents them to software as two layers of registers. Each port keeps a small event register. The port logic sets its bits with one-cycle pulses, and software clears them by writing ones. Each port also has a mask register. When any unmasked event is present, the port raises a read-only pending bit. At the host layer the pending bits of the ports and a software-raised interrupt pass through a host mask. The unmasked host sources are then summarised into a read-only global bit, and that bit drives the single interrupt output unless a global off bit is set.

A host control register carries the global off bit and a soft-reset bit. Writing one to the soft-reset bit starts a fixed-length reset of the port registers. The bit reads as one while the reset runs and then clears itself, so software polls it until it reads zero. The register port is a plain single-cycle write strobe with a combinational read, and no back-pressure exists on any pin. Address map with the defaults:

- Port p event register at 2p, port p mask register at 2p+1.
- Host status at 0x20, host mask at 0x21, host control at 0x22.

Top module: `hostirq_regs`

## Requirements
- R1: After reset, every port event register reads 0x0000, every port mask reads 0x00FF, and host status, host mask and host control read 0x0000. The interrupt output is low.
- R2: A one-cycle pulse on event input bit b of port p sets bit b of that port's event register, and the bit stays set until it is cleared. The six bits are 0 removed, 1 attached, 2 command done, 3 fatal error, 4 device interrupt and 5 reply queue not empty.
- R3: Writing the port event register clears each event bit whose data bit is 1 and leaves every bit written 0 unchanged. Data bits 6 and 7 have no effect, and writing 0xFF clears all events.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: Bit 7 of the port event register reads 1 exactly when some bit b in 0..5 is set with mask bit b clear. Bit 6 reads 0. The 8-bit mask reads back as written, and a mask of 0xFF holds bit 7 at 0 whatever events are present.
- R6: Host status bit p equals port p's pending bit ANDed with NOT host mask bit p. Host mask bits 0..14 read back as written, and host mask bit 15 reads 0.
- R7: Writing host status stores data bit 14 as the software interrupt flag and ignores all other data bits. Host status bit 14 reads the flag ANDed with NOT host mask bit 14.
- R8: Host status bit 15 is the OR of host status bits 0..14. The interrupt output equals bit 15 ANDed with NOT host control bit 8.
- R9: Host control bits other than 13 store the written value. After a write with bit 13 set, bit 13 reads 1 for the next 3 cycles and then reads 0. Writing 0 to bit 13 does not stop a running reset.
- R10: While the soft reset runs, every port event register is cleared and every port mask is forced to 0xFF. Event pulses and port register writes in those cycles are lost. Host mask, the software flag and the other host control bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NPORTS*EVW (12) | Event pulses, port p on bits p*EVW+5..p*EVW |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | AW (6) | Register address |
| reg_wdata | input | DW (16) | Write data |
| reg_rdata | output | DW (16) | Read data for reg_addr, combinational |
| irq_o | output | 1 | Interrupt output |

## Verification
On every cycle, the assertions check four things: an event pulse outside a soft reset is never lost, even when a clear of the same bit lands with it; a clearing write empties the bits it names unless they are re-raised; a frozen port never shows pending; and the global off bit keeps the output low. They also check that the soft-reset timer starts on a write and counts down without restarting, and that each reset cycle leaves the port registers cleared and frozen. Some behaviours can only be shown by the bench's scenarios: the mask sweep over all 256 values on each port, the exact number of cycles the reset bit reads 1, events lost during the reset, and the host mask and software flag surviving it.

// File: rtl/hir_pkg.sv
package hir_pkg;
  localparam int HIR_PW        = 8;
  localparam int HIR_DW        = 16;
  localparam int PB_PENDING    = 7;
  localparam int HB_SOFT       = 14;
  localparam int HB_GLOBAL     = 15;
  localparam int CB_IRQ_OFF    = 8;
  localparam int CB_SOFT_RESET = 13;
endpackage

// File: rtl/hir_port.sv
module hir_port
  import hir_pkg::*;
#(
  parameter int EVW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVW-1:0]    evt_i,
  input  logic              we_stat_i,
  input  logic              we_mask_i,
  input  logic [HIR_PW-1:0] wdata_i,
  input  logic              srst_i,
  output logic [HIR_PW-1:0] stat_o,
  output logic [HIR_PW-1:0] mask_o,
  output logic              pend_o
);
  localparam int PADW = HIR_PW - 1 - EVW;

  logic [EVW-1:0]    stat_q;
  logic [HIR_PW-1:0] mask_q;
  logic [EVW-1:0]    clr;

  assign clr = we_stat_i ? wdata_i[EVW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
    end else if (srst_i) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= (stat_q & ~clr) | evt_i;
      if (we_mask_i) mask_q <= wdata_i;
    end
  end

  assign pend_o = |(stat_q & ~mask_q[EVW-1:0]);
  assign stat_o = {pend_o, {PADW{1'b0}}, stat_q};
  assign mask_o = mask_q;

  // R4: an event outside a soft reset is never lost
  a_r4_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_i) && !srst_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  // R3: written ones are cleared unless re-raised
  a_r3_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (we_stat_i && !srst_i) |=> ((stat_q & $past(wdata_i[EVW-1:0] & ~evt_i)) == '0));

  // R5: a frozen port never shows pending
  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !pend_o);

  // R10: a reset cycle leaves the port cleared and frozen
  a_r10_port_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (stat_q == '0 && (&mask_q)));
endmodule

// File: rtl/hir_srst.sv
module hir_srst #(
  parameter int CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (start_i && cnt_q == '0)   cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R9: a start request from idle makes the reset run
  a_r9_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R9: a running reset counts down and is not restarted
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/hir_host.sv
module hir_host
  import hir_pkg::*;
#(
  parameter int NP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NP-1:0]     pend_i,
  input  logic              we_stat_i,
  input  logic              we_mask_i,
  input  logic              we_ctrl_i,
  input  logic [HIR_DW-1:0] wdata_i,
  input  logic              busy_i,
  output logic [HIR_DW-1:0] stat_o,
  output logic [HIR_DW-1:0] mask_o,
  output logic [HIR_DW-1:0] ctrl_o,
  output logic              start_o,
  output logic              irq_o
);
  localparam logic [HIR_DW-1:0] SRST_BIT = HIR_DW'(1) << CB_SOFT_RESET;

  logic [HIR_DW-2:0] hmask_q;
  logic [HIR_DW-1:0] ctrl_q;
  logic              soft_q;
  logic [HIR_DW-2:0] src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hmask_q <= '0;
      ctrl_q  <= '0;
      soft_q  <= 1'b0;
    end else begin
      if (we_mask_i) hmask_q <= wdata_i[HIR_DW-2:0];
      if (we_ctrl_i) ctrl_q  <= wdata_i & ~SRST_BIT;
      if (we_stat_i) soft_q  <= wdata_i[HB_SOFT];
    end
  end

  always_comb begin
    src = '0;
    src[NP-1:0] = pend_i & ~hmask_q[NP-1:0];
    src[HB_SOFT] = soft_q & ~hmask_q[HB_SOFT];
  end

  assign stat_o  = {|src, src};
  assign mask_o  = {1'b0, hmask_q};
  assign ctrl_o  = ctrl_q | (busy_i ? SRST_BIT : '0);
  assign start_o = we_ctrl_i && wdata_i[CB_SOFT_RESET];
  assign irq_o   = stat_o[HB_GLOBAL] & ~ctrl_q[CB_IRQ_OFF];

  // R6/R8: an unmasked pending port reaches the global bit
  a_r6_port_reaches_global: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_i & ~hmask_q[NP-1:0])) |-> stat_o[HB_GLOBAL]);

  // R8: the global off bit keeps the output low
  a_r8_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[CB_IRQ_OFF] |-> !irq_o);
endmodule

// File: rtl/hostirq_regs.sv
module hostirq_regs
  import hir_pkg::*;
#(
  parameter int NPORTS     = 2,
  parameter int EVW        = 6,
  parameter int RST_CYCLES = 3,
  parameter int AW         = 6,
  parameter int HOST_BASE  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORTS*EVW-1:0] evt_i,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [HIR_DW-1:0]     reg_wdata,
  output logic [HIR_DW-1:0]     reg_rdata,
  output logic                  irq_o
);
  localparam logic [AW-1:0] A_HSTAT = AW'(HOST_BASE);
  localparam logic [AW-1:0] A_HMASK = AW'(HOST_BASE + 1);
  localparam logic [AW-1:0] A_HCTRL = AW'(HOST_BASE + 2);

  logic [HIR_PW-1:0] pstat [NPORTS];
  logic [HIR_PW-1:0] pmask [NPORTS];
  logic [NPORTS-1:0] pend;
  logic [HIR_DW-1:0] hstat, hmask, hctrl;
  logic              busy, start;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    hir_port #(.EVW(EVW)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i[p*EVW +: EVW]),
      .we_stat_i (reg_we && reg_addr == AW'(2*p)),
      .we_mask_i (reg_we && reg_addr == AW'(2*p+1)),
      .wdata_i   (reg_wdata[HIR_PW-1:0]),
      .srst_i    (busy),
      .stat_o    (pstat[p]),
      .mask_o    (pmask[p]),
      .pend_o    (pend[p])
    );
  end

  hir_srst #(.CYCLES(RST_CYCLES)) u_srst (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .busy_o  (busy)
  );

  hir_host #(.NP(NPORTS)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend),
    .we_stat_i (reg_we && reg_addr == A_HSTAT),
    .we_mask_i (reg_we && reg_addr == A_HMASK),
    .we_ctrl_i (reg_we && reg_addr == A_HCTRL),
    .wdata_i   (reg_wdata),
    .busy_i    (busy),
    .stat_o    (hstat),
    .mask_o    (hmask),
    .ctrl_o    (hctrl),
    .start_o   (start),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (reg_addr == AW'(2*p))   reg_rdata = HIR_DW'(pstat[p]);
      if (reg_addr == AW'(2*p+1)) reg_rdata = HIR_DW'(pmask[p]);
    end
    if (reg_addr == A_HSTAT) reg_rdata = hstat;
    if (reg_addr == A_HMASK) reg_rdata = hmask;
    if (reg_addr == A_HCTRL) reg_rdata = hctrl;
  end
endmodule

// File: tb/sim_hostirq_regs.sv
module sim_hostirq_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam logic [5:0] A_HSTAT = 6'h20, A_HMASK = 6'h21, A_HCTRL = 6'h22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostirq_regs u0 (.clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [11:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic rchk(input string req, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int p = 0; p < NP; p++) begin
      rchk("R1 port stat", 6'(2*p), 16'h0000);
      rchk("R1 port mask", 6'(2*p+1), 16'h00FF);
    end
    rchk("R1 hstat", A_HSTAT, 16'h0000);
    rchk("R1 hmask", A_HMASK, 16'h0000);
    rchk("R1 hctrl", A_HCTRL, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2/R5/R6/R8: mask sweep per port with all events present
    for (int p = 0; p < NP; p++) begin
      pulse(12'(6'h3F) << (6*p));
      for (int m = 0; m < 256; m++) begin
        logic pe;
        pe = ((6'h3F & ~m[5:0]) != 0);
        wr(6'(2*p+1), 16'(m));
        rchk("R5 mask readback", 6'(2*p+1), 16'(m));
        rchk("R2 R5 port stat", 6'(2*p), {8'h00, pe, 1'b0, 6'h3F});
        rchk("R6 R8 hstat", A_HSTAT, pe ? (16'h8000 | (16'h1 << p)) : 16'h0000);
        chk("R8 irq", {15'd0, irq}, {15'd0, pe});
      end
      wr(6'(2*p+1), 16'h0000);
      // R3: partial clear, ignored upper bits, full clear
      wr(6'(2*p), 16'h0015);
      rchk("R3 partial clear", 6'(2*p), 16'h00AA);
      wr(6'(2*p), 16'h00C0);
      rchk("R3 bits 6 7 no effect", 6'(2*p), 16'h00AA);
      wr(6'(2*p), 16'h00FF);
      rchk("R3 clear all", 6'(2*p), 16'h0000);
      chk("R3 irq low", {15'd0, irq}, 16'h0000);
      // R2 individual bits
      for (int b = 0; b < 6; b++) begin
        pulse(12'(1) << (6*p + b));
        rchk("R2 single bit", 6'(2*p), {8'h00, 1'b1, 1'b0, 6'(1 << b)});
        wr(6'(2*p), 16'(1 << b));
        rchk("R2 bit cleared", 6'(2*p), 16'h0000);
      end
    end

    // R4: event and clear on the same bit in one cycle
    pulse(12'h004);
    @(negedge clk); evt = 12'h004; addr = 6'h00; wdata = 16'h0004; we = 1'b1;
    @(negedge clk); evt = '0; we = 1'b0;
    rchk("R4 event kept", 6'h00, 16'h0084);
    wr(6'h00, 16'h00FF);

    // R6: host mask gates a port, bit 15 not stored
    pulse(12'h040);
    wr(A_HMASK, 16'hFFFF);
    rchk("R6 hmask readback", A_HMASK, 16'h7FFF);
    rchk("R6 port1 masked", A_HSTAT, 16'h0000);
    chk("R6 irq masked", {15'd0, irq}, 16'h0000);
    rchk("R6 port pending kept", 6'h02, 16'h0081);
    wr(A_HMASK, 16'h0001);
    rchk("R6 port1 unmasked", A_HSTAT, 16'h8002);
    wr(6'h02, 16'h00FF);

    // R7: software interrupt
    wr(A_HSTAT, 16'hBFFF);
    rchk("R7 other bits ignored", A_HSTAT, 16'h0000);
    wr(A_HSTAT, 16'h4000);
    rchk("R7 soft set", A_HSTAT, 16'hC000);
    chk("R7 irq", {15'd0, irq}, 16'h0001);
    wr(A_HMASK, 16'h4000);
    rchk("R7 soft masked", A_HSTAT, 16'h0000);
    wr(A_HMASK, 16'h0000);

    // R8: global off
    wr(A_HCTRL, 16'h0100);
    rchk("R8 hstat still global", A_HSTAT, 16'hC000);
    chk("R8 irq off", {15'd0, irq}, 16'h0000);
    wr(A_HCTRL, 16'h0000);
    chk("R8 irq back", {15'd0, irq}, 16'h0001);

    // R9/R10: soft reset
    pulse(12'hFFF);
    wr(6'h01, 16'h0000);
    wr(A_HMASK, 16'h0002);
    wr(A_HCTRL, 16'h2100);
    rd(A_HCTRL, d); chk("R9 busy cycle 1", d, 16'h2100);
    evt = 12'hFFF;
    @(negedge clk); evt = '0;
    rd(A_HCTRL, d); chk("R9 busy cycle 2", d, 16'h2100);
    addr = A_HCTRL; wdata = 16'h0100; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(A_HCTRL, d); chk("R9 busy cycle 3 no stop", d, 16'h2100);
    @(negedge clk);
    rd(A_HCTRL, d); chk("R9 self cleared", d, 16'h0100);
    rchk("R10 port0 cleared", 6'h00, 16'h0000);
    rchk("R10 port1 cleared", 6'h02, 16'h0000);
    rchk("R10 port0 mask", 6'h01, 16'h00FF);
    rchk("R10 port1 mask", 6'h03, 16'h00FF);
    rchk("R10 hmask kept", A_HMASK, 16'h0002);
    rchk("R10 soft kept", A_HSTAT, 16'hC000);
    chk("R10 irq off kept", {15'd0, irq}, 16'h0000);
    wr(6'h01, 16'h0000);
    pulse(12'h001);
    rchk("R10 port usable after", 6'h00, 16'h0081);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule